// File: doc/BRIEF.md
# Subcarrier Load-Modulation Reply Transmitter

This block sends the tag's answers back to a reader by load modulation. It switches a roughly 212 kHz subcarrier on for a 1 and leaves it off for a 0. Each bit occupies a fixed slot of 21 ticks. One tick is one subcarrier period, which is 64 cycles of the 13.56 MHz carrier clock. The subcarrier and the tick count both come from a free-running divider of that clock. The tick count is brought out so that the receive side can time-stamp the end of each reader frame in the same time base.

A reply is requested with a single-cycle start. The request carries a kind (a data frame or a write acknowledge), the frame bits, their length and the tick stamp at which the reader's frame ended. The reply does not start at the request. It starts at a fixed delay after that stamp: 70 ticks for data, 758 ticks for an acknowledge.

While the block waits for the reply to start, it pulls the external keystream forward by the number of slots that pass idle, less one: 2 steps for data, 35 steps for an acknowledge. Data bits leave least significant bit first, each XORed with the keystream bit. An acknowledge is a single clear 1. Every sent bit is followed by one keystream step. When the last slot ends, a done pulse follows.

Top module: `subcarrier_reply_tx`

## Requirements
- R1: After a synchronous active-low reset, `sc_drive`, `ks_adv` and `tx_done` are 0 and `tick_now` is 0.
- R2: `sc_drive` equals the current bit value ANDed with bit 5 of a 6-bit carrier divider that counts up by one every clock from reset. The subcarrier therefore has a period of 64 clocks and is high for the second 32 clocks of each period.
- R3: With `tx_kind`=0 (data), the first slot starts when `tick_now` first reaches `ref_stamp`+70. Each later slot starts when the count reaches the previous slot's start stamp plus 21. Slot ends are never measured from the moment a slot's drive began. A slot begins driving two clocks after the cycle in which the count reaches its stamp.
- R4: After a data request is accepted, `ks_adv` is high for exactly 2 consecutive clocks before the first slot.
- R5: Data bits are sent starting from `tx_data[0]`, `tx_len` bits in all (1 to 24). Each bit is XORed with the `ks_bit` value present when its slot is loaded. `ks_adv` is high for one clock at the end of each slot and is never high while the block is idle.
- R6: With `tx_kind`=1 (acknowledge), `tx_data` and `tx_len` are ignored. `ks_adv` is high for 35 clocks, then one slot carrying an unscrambled 1 starts at `ref_stamp`+758 ticks, followed by one more `ks_adv`.
- R7: The drive is off (`sc_drive`=0) at all times outside a frame's slots, including the done cycle.
- R8: `tx_done` is high for exactly one clock, one clock after the last slot ends, and the block is idle in the following clock.
- R9: A `tx_start` while a reply is in progress is ignored. It changes neither the reply in progress nor any output afterwards.
- R10: `tick_now` increments by one every 64 clocks, stepping on the clock after the divider reaches 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.56 MHz carrier clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Single-cycle reply request, taken only when idle |
| tx_kind | input | 1 | 0 = data frame, 1 = write acknowledge |
| tx_data | input | 24 | Frame bits, bit 0 sent first |
| tx_len | input | 5 | Number of data bits, 1 to 24 |
| ref_stamp | input | 16 | Tick stamp of the reader frame end |
| ks_bit | input | 1 | Current keystream bit |
| sc_drive | output | 1 | Gated subcarrier load-modulation drive |
| ks_adv | output | 1 | Keystream advance strobe |
| tx_done | output | 1 | One-cycle pulse after the last slot |
| tick_now | output | 16 | Free-running tick count |

## Verification
On every cycle the checker enforces several local rules. The done pulse is one cycle wide, leaves the subcarrier off and returns the block to idle. The tick count moves only in unit steps. No keystream step is taken while idle. A request arriving mid-reply leaves the latched reply kind alone. The exact start of each slot is not covered there, nor the XOR of each bit with the right keystream value, nor the 2 or 35 pre-steps, nor the shape of the acknowledge. Those show up only when the bench's reference model runs whole frames and an ignored request through the block and compares the outputs on every clock.

// File: rtl/subcarrier_reply_tx.sv
module subcarrier_reply_tx #(
  parameter int DIV_W      = 6,
  parameter int TS_W       = 16,
  parameter int DATA_W     = 24,
  parameter int LEN_W      = 5,
  parameter int SLOT_TICKS = 21,
  parameter int DATA_WAIT  = 70,
  parameter int ACK_WAIT   = 758
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic              tx_kind,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [TS_W-1:0]   ref_stamp,
  input  logic              ks_bit,
  output logic              sc_drive,
  output logic              ks_adv,
  output logic              tx_done,
  output logic [TS_W-1:0]   tick_now
);

  localparam int DATA_PRE = DATA_WAIT / SLOT_TICKS - 1;
  localparam int ACK_PRE  = ACK_WAIT / SLOT_TICKS - 1;
  localparam int PRE_W    = $clog2(ACK_PRE + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_WAIT, S_LOAD, S_BIT, S_DONE} st_t;

  st_t               st;
  logic [DIV_W-1:0]  div;
  logic [TS_W-1:0]   tick;
  logic [TS_W-1:0]   target;
  logic [DATA_W-1:0] dat;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  idx;
  logic [PRE_W-1:0]  pre_cnt;
  logic              kind_q;
  logic              drv;
  logic              busy;
  logic              due;
  logic [TS_W-1:0]   gap;

  assign busy = (st != S_IDLE);
  assign gap  = tick - target;
  assign due  = !gap[TS_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div  <= '0;
      tick <= '0;
    end else begin
      div <= div + DIV_W'(1);
      if (&div) tick <= tick + TS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      target  <= '0;
      dat     <= '0;
      len_q   <= '0;
      idx     <= '0;
      pre_cnt <= '0;
      kind_q  <= 1'b0;
      drv     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (tx_start && !busy) begin
          kind_q  <= tx_kind;
          dat     <= tx_data;
          len_q   <= tx_kind ? LEN_W'(1) : tx_len;
          idx     <= '0;
          target  <= ref_stamp + (tx_kind ? TS_W'(ACK_WAIT) : TS_W'(DATA_WAIT));
          pre_cnt <= tx_kind ? PRE_W'(ACK_PRE) : PRE_W'(DATA_PRE);
          st      <= S_PRE;
        end
        S_PRE: begin
          pre_cnt <= pre_cnt - PRE_W'(1);
          if (pre_cnt == PRE_W'(1)) st <= S_WAIT;
        end
        S_WAIT: if (due) st <= S_LOAD;
        S_LOAD: begin
          drv    <= kind_q ? 1'b1 : (dat[0] ^ ks_bit);
          target <= target + TS_W'(SLOT_TICKS);
          st     <= S_BIT;
        end
        S_BIT: if (due) begin
          if (idx + LEN_W'(1) == len_q) begin
            drv <= 1'b0;
            st  <= S_DONE;
          end else begin
            idx <= idx + LEN_W'(1);
            dat <= dat >> 1;
            st  <= S_LOAD;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sc_drive = drv & div[DIV_W-1];
  assign ks_adv   = (st == S_PRE) || ((st == S_BIT) && due);
  assign tx_done  = (st == S_DONE);
  assign tick_now = tick;

endmodule

// File: rtl/subcarrier_reply_tx_chk.sv
module subcarrier_reply_tx_chk #(
  parameter int TS_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            start,
  input logic            kind_q,
  input logic            done,
  input logic            adv,
  input logic            sc,
  input logic [TS_W-1:0] tick
);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !sc);

  // R10
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick != $past(tick)) |-> (tick == $past(tick) + TS_W'(1)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(kind_q));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !adv);

endmodule

bind subcarrier_reply_tx subcarrier_reply_tx_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start(tx_start), .kind_q(kind_q),
  .done(tx_done), .adv(ks_adv), .sc(sc_drive), .tick(tick_now)
);

// File: tb/sim_subcarrier_reply_tx.sv
module sim_subcarrier_reply_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_start = 1'b0;
  logic        tx_kind = 1'b0;
  logic [23:0] tx_data = '0;
  logic [4:0]  tx_len = '0;
  logic [15:0] ref_stamp = '0;
  logic        ks_bit;
  logic        sc_drive, ks_adv, tx_done;
  logic [15:0] tick_now;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  subcarrier_reply_tx u0 (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_kind(tx_kind),
    .tx_data(tx_data), .tx_len(tx_len), .ref_stamp(ref_stamp), .ks_bit(ks_bit),
    .sc_drive(sc_drive), .ks_adv(ks_adv), .tx_done(tx_done), .tick_now(tick_now)
  );

  // keystream source: steps on the edge after a sampled strobe
  logic [6:0] ks_lfsr = 7'h55;
  logic       adv_seen = 1'b0;
  assign ks_bit = ks_lfsr[0];
  always @(negedge clk) adv_seen <= ks_adv;
  always @(posedge clk) if (adv_seen) ks_lfsr <= {ks_lfsr[5:0], ks_lfsr[6] ^ ks_lfsr[5]};

  // behavioural reference model
  int m_cyc = 0;
  int m_phase = 0;
  int m_pre = 0;
  int m_target = 0;
  int m_kind = 0;
  bit m_drv = 0;
  bit mq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_phase = 0; m_drv = 0; mq.delete();
    end else begin
      case (m_phase)
        0: if (tx_start) begin
          m_kind = tx_kind;
          mq.delete();
          if (tx_kind) mq.push_back(1'b1);
          else for (int i = 0; i < int'(tx_len); i++) mq.push_back(tx_data[i]);
          m_target = int'(ref_stamp) + (tx_kind ? 758 : 70);
          m_pre = tx_kind ? 35 : 2;
          m_phase = 1;
        end
        1: begin m_pre--; if (m_pre == 0) m_phase = 2; end
        2: if (m_cyc / 64 >= m_target) m_phase = 3;
        3: begin
          m_drv = m_kind ? 1'b1 : (mq[0] ^ ks_bit);
          m_target += 21;
          m_phase = 4;
        end
        4: if (m_cyc / 64 >= m_target) begin
          void'(mq.pop_front());
          if (mq.size() == 0) begin m_drv = 0; m_phase = 5; end
          else m_phase = 3;
        end
        default: m_phase = 0;
      endcase
      m_cyc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_sc, e_adv, e_done;
      e_sc   = m_drv && ((m_cyc % 64) >= 32);
      e_adv  = (m_phase == 1) || (m_phase == 4 && m_cyc / 64 >= m_target);
      e_done = (m_phase == 5);
      checks += 4;
      if (sc_drive !== e_sc) begin
        errors++;
        $display("FAIL R2/R3/R5/R6/R7 sc_drive cyc %0d got %b exp %b", m_cyc, sc_drive, e_sc);
      end
      if (ks_adv !== e_adv) begin
        errors++;
        $display("FAIL R4/R5/R6 ks_adv cyc %0d got %b exp %b", m_cyc, ks_adv, e_adv);
      end
      if (tx_done !== e_done) begin
        errors++;
        $display("FAIL R8 tx_done cyc %0d got %b exp %b", m_cyc, tx_done, e_done);
      end
      if (int'(tick_now) != m_cyc / 64) begin
        errors++;
        $display("FAIL R10 tick_now got %0d exp %0d", tick_now, m_cyc / 64);
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // send a reply; optionally poke a second request mid-reply
  task automatic send(input bit k, input logic [23:0] d, input logic [4:0] l,
                      input bit poke, output int advs, output int dones);
    int n;
    @(negedge clk);
    tx_kind = k; tx_data = d; tx_len = l; ref_stamp = tick_now; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    advs = 0; dones = 0; n = 0;
    do begin
      if (ks_adv) advs++;
      if (tx_done) dones++;
      if (poke && n == 100) begin
        tx_kind = 1'b1; tx_data = 24'hFFFFFF; tx_len = 5'd24;
        ref_stamp = tick_now; tx_start = 1'b1;
      end else tx_start = 1'b0;
      n++;
      @(negedge clk);
    end while (dones == 0);
    tx_start = 1'b0;
    check("R8 done width", int'(tx_done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int a, d, t0, quiet;
    repeat (3) @(negedge clk);
    check("R1 sc_drive", int'(sc_drive), 0);
    check("R1 ks_adv", int'(ks_adv), 0);
    check("R1 tx_done", int'(tx_done), 0);
    check("R1 tick_now", int'(tick_now), 0);
    rst_n = 1'b1;
    @(negedge clk);
    t0 = int'(tick_now);
    repeat (640) @(negedge clk);
    check("R10 ticks over 640 clocks", int'(tick_now) - t0, 10);

    send(1'b0, 24'h000A5C, 5'd12, 1'b0, a, d);
    check("R4 R5 advances 12-bit data", a, 14);
    check("R8 done count", d, 1);

    send(1'b0, 24'h00002B, 5'd6, 1'b0, a, d);
    check("R4 R5 advances 6-bit data", a, 8);

    send(1'b1, 24'h123456, 5'd9, 1'b0, a, d);
    check("R6 advances acknowledge", a, 36);
    check("R6 done count", d, 1);

    send(1'b0, 24'h0001F3, 5'd9, 1'b1, a, d);
    check("R9 advances with ignored request", a, 11);
    quiet = 0;
    for (int i = 0; i < 3000; i++) begin
      if (ks_adv || tx_done || sc_drive) quiet++;
      @(negedge clk);
    end
    check("R9 activity after ignored request", quiet, 0);

    send(1'b0, 24'h800001, 5'd24, 1'b0, a, d);
    check("R5 advances 24-bit data", a, 26);
    finish_run();
  end
endmodule